// File: doc/BRIEF.md
# Cache Tag Walk Commit and Rollback Engine

This block updates the epoch metadata of every cache line held in a plain synchronous tag RAM. That RAM has no port that clears many entries at once, so the engine visits every line in turn. Each line holds a valid bit, a two-bit epoch code and an address tag. Epoch code 00 marks committed data. Codes 01 and 10 mark the two speculative epochs that are live.

A commit request carries a two-bit selection mask. Bit 0 selects epoch 01 and bit 1 selects epoch 10. The engine clears the epoch code of every line whose code is selected. A rollback request invalidates every line that holds speculative data and sets all epoch codes to 00.

While the engine is working it holds the pipeline stall output high. It owns the RAM during that time. The read of the next line overlaps the write-back of the current line, so the engine keeps a rate of one line per cycle. When the engine is idle, the cache controller uses a host port to write tag entries and to read them back with one cycle of latency.

Top module: `tag_walk_engine`

## Requirements
- R1: After reset, stall and done are low and every line reads back as valid 0, epoch 00, tag 0.
- R2: A rollback request, or a commit request with a non-zero mask, raises stall on the next cycle when the engine is idle. Stall then stays high for exactly LINES+2 cycles: LINES+1 walk cycles and one restore cycle. Walk write-backs go to consecutive line addresses, one per cycle.
- R3: Done is high for exactly one cycle. That cycle is the last cycle in which stall is high.
- R4: A commit with a one-bit mask clears the epoch code of every line whose code is selected to 00. Mask bit 0 selects code 01 and mask bit 1 selects code 10. The valid bit and the tag of each line are kept. Lines with any other epoch code are left unchanged.
- R5: A commit with mask 11 clears both code 01 and code 10 in a single walk. Code 11 and code 00 are left unchanged.
- R6: A rollback clears the valid bit of every line whose epoch code is non-zero, sets every epoch code to 00, and keeps every tag.
- R7: When a rollback request and a commit request arrive together, the engine performs only the rollback walk. The commit is absorbed and no second walk follows.
- R8: A request that arrives while stall is high is held. After the current walk finishes, the engine spends one idle cycle with stall low and then starts a full walk for the held request.
- R9: Host writes presented while stall is high are dropped.
- R10: When the engine is idle, a host read returns the entry at host_raddr on the cycle after the address is presented.
- R11: A commit request with mask 00 is ignored. Stall stays low and no line changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| commit_req | input | 1 | Commit request pulse |
| commit_sel | input | 2 | Epoch selection mask for a commit |
| rollback_req | input | 1 | Rollback request pulse |
| stall | output | 1 | Pipeline stall; high while the engine owns the tag RAM |
| done | output | 1 | One-cycle pulse at the end of a walk |
| host_we | input | 1 | Host tag write enable |
| host_waddr | input | $clog2(LINES) | Host write line index |
| host_wvalid | input | 1 | Valid bit to write |
| host_wepoch | input | 2 | Epoch code to write |
| host_wtag | input | TAG_W | Address tag to write |
| host_raddr | input | $clog2(LINES) | Host read line index |
| host_rvalid | output | 1 | Valid bit read back |
| host_repoch | output | 2 | Epoch code read back |
| host_rtag | output | TAG_W | Address tag read back |

## Verification
If the walk counter or the state register is wrong, the length of the stall window or the position of the done pulse changes. That shows up at the ports on the very next request. A fault in the read-modify-write pairing writes a neighbour's data, or a stale read word, into a line. That corruption stays hidden until the cache controller reads the line back after the walk, so the bench reads back every line after every walk. If held requests are lost or merged wrongly, the stall does not rise again one idle cycle after done. If rollback priority is wrong, an extra walk appears after the rollback.

// File: rtl/tag_walk_pkg.sv
package tag_walk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WALK    = 2'd1,
    ST_RESTORE = 2'd2
  } walk_state_e;

  // Epoch code after a commit with the given selection mask.
  function automatic logic [1:0] epoch_after_commit(input logic [1:0] ep, input logic [1:0] sel);
    logic hit;
    hit = (ep == 2'b01 && sel[0]) || (ep == 2'b10 && sel[1]);
    return hit ? 2'b00 : ep;
  endfunction

  // Valid bit after a rollback: speculative lines are dropped.
  function automatic logic valid_after_rollback(input logic v, input logic [1:0] ep);
    return v && (ep == 2'b00);
  endfunction

endpackage

// File: rtl/tag_ram.sv
module tag_ram #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 11,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdata <= '0;
    end else begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
    end
  end
endmodule

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import tag_walk_pkg::*;
#(
  parameter int LINES = 16,
  localparam int IDX_W = $clog2(LINES),
  localparam int CNT_W = $clog2(LINES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_req,
  input  logic [1:0]       commit_sel,
  input  logic             rollback_req,
  output logic             stall,
  output logic             done,
  output logic             walk_wen,
  output logic [IDX_W-1:0] walk_raddr,
  output logic [IDX_W-1:0] walk_waddr,
  output logic             op_rb,
  output logic [1:0]       op_sel,
  output logic             start
);
  walk_state_e      state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_m1;
  logic             pend_rb;
  logic [1:0]       pend_sel;
  logic             want_rb;
  logic [1:0]       want_sel;

  always_comb begin
    want_rb  = pend_rb | rollback_req;
    want_sel = pend_sel | (commit_req ? commit_sel : 2'b00);
    start    = (state == ST_IDLE) && (want_rb || (want_sel != 2'b00));
    cnt_m1   = cnt - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      pend_rb  <= 1'b0;
      pend_sel <= 2'b00;
      op_rb    <= 1'b0;
      op_sel   <= 2'b00;
    end else begin
      if (start) begin
        pend_rb  <= 1'b0;
        pend_sel <= 2'b00;
        op_rb    <= want_rb;
        op_sel   <= want_rb ? 2'b00 : want_sel;
      end else begin
        pend_rb  <= want_rb;
        pend_sel <= want_sel;
      end
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_WALK;
          cnt   <= '0;
        end
        ST_WALK: begin
          cnt <= cnt + CNT_W'(1);
          if (cnt == CNT_W'(LINES)) state <= ST_RESTORE;
        end
        ST_RESTORE: state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  assign stall      = (state != ST_IDLE);
  assign done       = (state == ST_RESTORE);
  assign walk_wen   = (state == ST_WALK) && (cnt != '0);
  assign walk_raddr = cnt[IDX_W-1:0];
  assign walk_waddr = cnt_m1[IDX_W-1:0];
endmodule

// File: rtl/tag_walk_engine.sv
module tag_walk_engine
  import tag_walk_pkg::*;
#(
  parameter int LINES = 16,
  parameter int TAG_W = 8,
  localparam int IDX_W = $clog2(LINES),
  localparam int ENTRY_W = TAG_W + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_req,
  input  logic [1:0]       commit_sel,
  input  logic             rollback_req,
  output logic             stall,
  output logic             done,
  input  logic             host_we,
  input  logic [IDX_W-1:0] host_waddr,
  input  logic             host_wvalid,
  input  logic [1:0]       host_wepoch,
  input  logic [TAG_W-1:0] host_wtag,
  input  logic [IDX_W-1:0] host_raddr,
  output logic             host_rvalid,
  output logic [1:0]       host_repoch,
  output logic [TAG_W-1:0] host_rtag
);
  logic               walk_wen;
  logic [IDX_W-1:0]   walk_raddr;
  logic [IDX_W-1:0]   walk_waddr;
  logic               op_rb;
  logic [1:0]         op_sel;
  logic               walk_start;
  logic               ram_we;
  logic [IDX_W-1:0]   ram_waddr;
  logic [IDX_W-1:0]   ram_raddr;
  logic [ENTRY_W-1:0] ram_wdata;
  logic [ENTRY_W-1:0] ram_rdata;
  logic [ENTRY_W-1:0] walk_line;

  walk_ctrl #(.LINES(LINES)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .commit_req(commit_req), .commit_sel(commit_sel), .rollback_req(rollback_req),
    .stall(stall), .done(done),
    .walk_wen(walk_wen), .walk_raddr(walk_raddr), .walk_waddr(walk_waddr),
    .op_rb(op_rb), .op_sel(op_sel), .start(walk_start)
  );

  // Line transform for the write-back half of the read-modify-write.
  always_comb begin
    logic             v;
    logic [1:0]       ep;
    logic [TAG_W-1:0] tg;
    v  = ram_rdata[ENTRY_W-1];
    ep = ram_rdata[TAG_W +: 2];
    tg = ram_rdata[TAG_W-1:0];
    if (op_rb) walk_line = {valid_after_rollback(v, ep), 2'b00, tg};
    else       walk_line = {v, epoch_after_commit(ep, op_sel), tg};
  end

  // RAM port ownership: the walker while stalled, the host otherwise.
  always_comb begin
    ram_we    = walk_wen | (host_we & ~stall);
    ram_waddr = walk_wen ? walk_waddr : host_waddr;
    ram_wdata = walk_wen ? walk_line : {host_wvalid, host_wepoch, host_wtag};
    ram_raddr = stall ? walk_raddr : host_raddr;
  end

  tag_ram #(.DEPTH(LINES), .WIDTH(ENTRY_W)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  assign host_rvalid = ram_rdata[ENTRY_W-1];
  assign host_repoch = ram_rdata[TAG_W +: 2];
  assign host_rtag   = ram_rdata[TAG_W-1:0];
endmodule

// File: rtl/tag_walk_engine_chk.sv
module tag_walk_engine_chk #(
  parameter int LINES = 16,
  parameter int TAG_W = 8,
  localparam int IDX_W = $clog2(LINES),
  localparam int ENTRY_W = TAG_W + 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               commit_req,
  input logic [1:0]         commit_sel,
  input logic               rollback_req,
  input logic               stall,
  input logic               done,
  input logic               walk_wen,
  input logic [IDX_W-1:0]   walk_waddr,
  input logic               ram_we,
  input logic               op_rb,
  input logic [ENTRY_W-1:0] rd_line,
  input logic [ENTRY_W-1:0] wr_line
);
  AST_REQ_STARTS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (rollback_req || (commit_req && commit_sel != 2'b00)) && !stall |=> stall); // R2
  AST_WALK_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    walk_wen && $past(walk_wen) |-> walk_waddr == IDX_W'($past(walk_waddr) + 1'b1)); // R2
  AST_DONE_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> stall); // R3
  AST_DONE_ENDS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !stall); // R3
  AST_TAG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    walk_wen |-> wr_line[TAG_W-1:0] == rd_line[TAG_W-1:0]); // R4
  AST_RB_EPOCH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    walk_wen && op_rb |-> wr_line[TAG_W +: 2] == 2'b00); // R6
  AST_RB_SPEC_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    walk_wen && op_rb && rd_line[TAG_W +: 2] != 2'b00 |-> !wr_line[ENTRY_W-1]); // R6
  AST_HOST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    stall && !walk_wen |-> !ram_we); // R9
endmodule

bind tag_walk_engine tag_walk_engine_chk #(.LINES(LINES), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .commit_req(commit_req), .commit_sel(commit_sel), .rollback_req(rollback_req),
  .stall(stall), .done(done),
  .walk_wen(walk_wen), .walk_waddr(walk_waddr), .ram_we(ram_we), .op_rb(op_rb),
  .rd_line(ram_rdata), .wr_line(ram_wdata)
);

// File: tb/tag_walk_engine_test.sv
module tag_walk_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 16;
  localparam int TAG_W = 8;
  localparam int IDX_W = $clog2(LINES);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic commit_req = 1'b0;
  logic [1:0] commit_sel = 2'b00;
  logic rollback_req = 1'b0;
  logic stall, done;
  logic host_we = 1'b0;
  logic [IDX_W-1:0] host_waddr = '0;
  logic host_wvalid = 1'b0;
  logic [1:0] host_wepoch = 2'b00;
  logic [TAG_W-1:0] host_wtag = '0;
  logic [IDX_W-1:0] host_raddr = '0;
  logic host_rvalid;
  logic [1:0] host_repoch;
  logic [TAG_W-1:0] host_rtag;

  int checks = 0;
  int errors = 0;

  logic             m_v  [LINES];
  logic [1:0]       m_ep [LINES];
  logic [TAG_W-1:0] m_tag[LINES];

  always #(CLK_PERIOD/2) clk = ~clk;

  tag_walk_engine #(.LINES(LINES), .TAG_W(TAG_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .commit_req(commit_req), .commit_sel(commit_sel), .rollback_req(rollback_req),
    .stall(stall), .done(done),
    .host_we(host_we), .host_waddr(host_waddr), .host_wvalid(host_wvalid),
    .host_wepoch(host_wepoch), .host_wtag(host_wtag),
    .host_raddr(host_raddr), .host_rvalid(host_rvalid),
    .host_repoch(host_repoch), .host_rtag(host_rtag)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Bench model of a commit: a line is cleared when its code is named by the mask.
  function automatic void model_commit(input logic [1:0] sel);
    for (int i = 0; i < LINES; i++) begin
      case (m_ep[i])
        2'b01: if (sel[0]) m_ep[i] = 2'b00;
        2'b10: if (sel[1]) m_ep[i] = 2'b00;
        default: ;
      endcase
    end
  endfunction

  function automatic void model_rollback();
    for (int i = 0; i < LINES; i++) begin
      if (m_ep[i] != 2'b00) m_v[i] = 1'b0;
      m_ep[i] = 2'b00;
    end
  endfunction

  task automatic host_write(input int idx, input logic v, input logic [1:0] ep, input logic [TAG_W-1:0] tg);
    host_we = 1'b1; host_waddr = IDX_W'(idx);
    host_wvalid = v; host_wepoch = ep; host_wtag = tg;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic fill(input int s);
    for (int i = 0; i < LINES; i++) begin
      m_v[i]   = ((i + s) % 3) != 0;
      m_ep[i]  = 2'((i + s) % 4);
      m_tag[i] = TAG_W'(i * 37 + s * 11);
      host_write(i, m_v[i], m_ep[i], m_tag[i]);
    end
  endtask

  // R10: one-cycle read latency; every line compared with the model.
  task automatic verify_all(input string req);
    host_raddr = '0;
    for (int i = 0; i < LINES; i++) begin
      @(negedge clk);
      check({host_rvalid, host_repoch, host_rtag} == {m_v[i], m_ep[i], m_tag[i]},
            {req, " R10 line"}, int'({host_rvalid, host_repoch, host_rtag}),
            int'({m_v[i], m_ep[i], m_tag[i]}));
      if (i + 1 < LINES) host_raddr = IDX_W'(i + 1);
    end
  endtask

  // Pulses a request and measures the stall window and the done position (R2, R3).
  task automatic run_op(input logic [1:0] sel, input logic rb, input logic cm, input string req);
    int n, done_at;
    commit_req = cm; commit_sel = sel; rollback_req = rb;
    @(negedge clk);
    commit_req = 1'b0; commit_sel = 2'b00; rollback_req = 1'b0;
    n = 0; done_at = -1;
    while (stall && n < LINES + 10) begin
      if (done) done_at = n;
      n++;
      @(negedge clk);
    end
    check(n == LINES + 2, {req, " R2 stall length"}, n, LINES + 2);
    check(done_at == LINES + 1, {req, " R3 done position"}, done_at, LINES + 1);
  endtask

  task automatic t_reset();
    check(stall == 1'b0, "R1 stall after reset", int'(stall), 0);
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
    verify_all("R1");
  endtask

  task automatic t_commit_one();
    fill(1);
    run_op(2'b01, 1'b0, 1'b1, "R4 sel01");
    model_commit(2'b01);
    verify_all("R4 sel01");
    fill(2);
    run_op(2'b10, 1'b0, 1'b1, "R4 sel10");
    model_commit(2'b10);
    verify_all("R4 sel10");
  endtask

  task automatic t_commit_both();
    fill(3);
    run_op(2'b11, 1'b0, 1'b1, "R5");
    model_commit(2'b11);
    verify_all("R5");
  endtask

  task automatic t_rollback();
    fill(4);
    run_op(2'b00, 1'b1, 1'b0, "R6");
    model_rollback();
    verify_all("R6");
  endtask

  task automatic t_priority();
    fill(5);
    run_op(2'b11, 1'b1, 1'b1, "R7");
    model_rollback();
    for (int k = 0; k < 3; k++) begin
      check(stall == 1'b0, "R7 no second walk", int'(stall), 0);
      @(negedge clk);
    end
    verify_all("R7");
  endtask

  task automatic t_busy();
    int n;
    fill(6);
    commit_req = 1'b1; commit_sel = 2'b01;
    @(negedge clk);
    commit_req = 1'b0; commit_sel = 2'b00;
    n = 0;
    while (stall && n < LINES + 10) begin
      if (n == 5) begin
        host_we = 1'b1; host_waddr = '0; host_wvalid = ~m_v[0];
        host_wepoch = ~m_ep[0]; host_wtag = ~m_tag[0];
      end
      if (n == 6) begin
        host_we = 1'b0;
        commit_req = 1'b1; commit_sel = 2'b10;
      end
      if (n == 7) begin
        commit_req = 1'b0; commit_sel = 2'b00;
      end
      n++;
      @(negedge clk);
    end
    check(n == LINES + 2, "R8 first walk length", n, LINES + 2);
    check(stall == 1'b0, "R8 idle gap", int'(stall), 0);
    @(negedge clk);
    check(stall == 1'b1, "R8 held request starts", int'(stall), 1);
    n = 0;
    while (stall && n < LINES + 10) begin
      n++;
      @(negedge clk);
    end
    check(n == LINES + 2, "R8 held walk length", n, LINES + 2);
    model_commit(2'b01);
    model_commit(2'b10);
    verify_all("R8 R9");
  endtask

  task automatic t_empty_mask();
    fill(7);
    commit_req = 1'b1; commit_sel = 2'b00;
    @(negedge clk);
    commit_req = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check(stall == 1'b0, "R11 empty mask ignored", int'(stall), 0);
      @(negedge clk);
    end
    verify_all("R11");
  endtask

  initial begin
    for (int i = 0; i < LINES; i++) begin
      m_v[i] = 1'b0; m_ep[i] = 2'b00; m_tag[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_commit_one();
    t_commit_both();
    t_rollback();
    t_priority();
    t_busy();
    t_empty_mask();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule